// File: doc/BRIEF.md
# Pushbutton Synchronizer and Debouncer

This block turns the raw pin of a mechanical pushbutton into two clean signals in the system clock domain. The first is a level that is high while the button is held. The second is a pulse that lasts one clock when a press is accepted. The pin idles high and is pulled low while the button is held, so the block inverts it. A two-stage synchronizer brings the inverted level into the clock domain.

The synchronized level is not used on every clock. A free-running counter runs on the system clock, and the rising edge of one of its bits gives a one-clock sample enable. With the defaults, this happens every 2^23 clocks. All filter registers use this enable, so the design has only one clock net. The debounced level takes a new value only when two back-to-back samples agree on it. Contact chatter that makes successive samples disagree therefore never reaches the output. A held button gives one long level and one pulse.

Top module: `btn_conditioner`

## Requirements
- R1: The output `pressed` is high when the pin has been steadily low, and low when the pin has been steadily high.
- R2: A pin level driven before clock edge k reaches the sampling logic at edge k+2, through two synchronizer flops.
- R3: A sample is taken once every 2^(TAP_BIT+1) clocks. It is taken at the edge where the counter's low TAP_BIT+1 bits equal 2^TAP_BIT. Counting starts from zero at the first edge after reset.
- R4: `pressed` changes only at a sample edge, and only when that sample and the sample before it both hold the new value. A single sample of a different value leaves `pressed` unchanged.
- R5: Chatter whose successive samples alternate never changes `pressed` and never produces a pulse.
- R6: `press_pulse` is high for exactly one clock, in the first cycle in which `pressed` is high after being low.
- R7: A release (`pressed` going from high to low) produces no pulse.
- R8: While the pin stays low, `pressed` stays high and no further pulse occurs.
- R9: While `rst` is high, the outputs are cleared at each clock edge. The block leaves reset in the released state, with the counter at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_n | input | 1 | Raw pushbutton pin, low while pressed, asynchronous |
| pressed | output | 1 | Debounced pressed level, active high |
| press_pulse | output | 1 | One-clock pulse when a press is accepted |

## Verification
The bench builds the block with CNT_W = 8 and TAP_BIT = 2, so a sample falls every 8 clocks rather than every 2^23. At that period, a press can be started at each of the eight phases relative to the sample enable in a few hundred cycles. The expected edge of each level change is computed from the phase. Chatter that flips once per sample period, a glitch that covers a single sample, a hold of dozens of sample periods and a reset in the middle of a press all fit within a short run.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;

  typedef enum logic {
    LVL_RELEASED = 1'b0,
    LVL_PRESSED  = 1'b1
  } btn_level_e;

  // True on the count value at which bit `tap` has just turned from 0 to 1.
  function automatic logic tap_hit(input logic [63:0] count, input int unsigned tap);
    logic [63:0] mask;
    mask = (64'd1 << (tap + 1)) - 64'd1;
    return (count & mask) == (64'd1 << tap);
  endfunction

  // Two successive samples agree.
  function automatic logic samples_agree(input logic now_s, input logic before_s);
    return now_s == before_s;
  endfunction

  // Level goes from released to pressed.
  function automatic logic press_edge(input logic next_lvl, input logic cur_lvl);
    return (next_lvl == LVL_PRESSED) && (cur_lvl == LVL_RELEASED);
  endfunction

endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic lvl
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  // Inversion at the entry: the chain carries an active-high level.
  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[LAST-1:0], ~pin_n};
  end

  assign lvl = chain[LAST];

endmodule

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
  parameter int CNT_W   = 32,
  parameter int TAP_BIT = 22
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  import btn_cond_pkg::*;

  localparam int PAD_W = 64 - CNT_W;

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_q + 1'b1;
  end

  assign tick = tap_hit({{PAD_W{1'b0}}, count_q}, TAP_BIT);

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R3

endmodule

// File: rtl/btn_filter.sv
module btn_filter (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic lvl_in,
  output logic deb,
  output logic rise
);
  import btn_cond_pkg::*;

  logic prev_s;
  logic deb_q;
  logic pulse_q;

  // Named events for the checks below.
  logic agree_w;
  logic set_w;

  assign agree_w = tick && samples_agree(lvl_in, prev_s);
  assign set_w   = agree_w && press_edge(lvl_in, deb_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_s  <= LVL_RELEASED;
      deb_q   <= LVL_RELEASED;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set_w;
      if (tick) begin
        prev_s <= lvl_in;
        if (agree_w) deb_q <= lvl_in;
      end
    end
  end

  assign deb  = deb_q;
  assign rise = pulse_q;

  AST_DEB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (deb_q != $past(deb_q)) |-> $past(tick)); // R4

endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int CNT_W   = 32,
  parameter int TAP_BIT = 22
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_n,
  output logic pressed,
  output logic press_pulse
);
  localparam int SYNC_STAGES = 2;

  logic lvl_sync;
  logic tick;

  btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (btn_n),
    .lvl   (lvl_sync)
  );

  btn_tick_gen #(.CNT_W(CNT_W), .TAP_BIT(TAP_BIT)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  btn_filter u_filter (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .lvl_in (lvl_sync),
    .deb    (pressed),
    .rise   (press_pulse)
  );

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (lvl_sync == !$past(btn_n, 2))); // R2

  AST_PULSE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    press_pulse |-> (pressed && !$past(pressed))); // R6

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    press_pulse |=> !press_pulse); // R6

  AST_NO_PULSE_ON_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(pressed) |-> !press_pulse); // R7

  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> (!pressed && !press_pulse)); // R9

endmodule

// File: tb/btn_conditioner_tb.sv
module btn_conditioner_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW  = 8;
  localparam int TAP = 2;
  localparam int PER = 1 << (TAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_n = 1'b1;
  logic pressed;
  logic press_pulse;

  always #2.5 clk = ~clk;

  btn_conditioner #(.CNT_W(CW), .TAP_BIT(TAP)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .btn_n       (btn_n),
    .pressed     (pressed),
    .press_pulse (press_pulse)
  );

  int ntests = 0;
  int nfail = 0;
  int ecnt = 0;
  int pulses_seen = 0;
  int pulses_exp = 0;
  bit prev_p = 1'b0;
  bit prev_pulse = 1'b0;

  typedef struct {
    int at_edge;
    bit lvl;
  } exp_t;
  exp_t sb_q[$];

  // Index of the next clock edge since reset release.
  always @(posedge clk) begin
    if (rst) ecnt <= 0;
    else     ecnt <= ecnt + 1;
  end

  function automatic int next_tick(input int n);
    int off;
    off = ((PER / 2) - (n % PER) + PER) % PER;
    return n + off;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    ntests++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Driver: set the pin; when a level change must follow, push the edge at
  // which it is due (second agreeing sample after the two-flop delay).
  task automatic drive(input bit pin_n, input bit expect_change);
    exp_t e;
    if (expect_change) begin
      e.at_edge = next_tick(ecnt + 2) + PER;
      e.lvl = !pin_n;
      sb_q.push_back(e);
      if (!pin_n) pulses_exp++;
    end
    btn_n = pin_n;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bounce(input bit first_pin_n, input int halves);
    for (int i = 0; i < halves; i++) begin
      btn_n = (i % 2 == 0) ? first_pin_n : !first_pin_n;
      idle(PER);
    end
  endtask

  // Monitor: pops expected changes and compares them as they appear.
  always @(negedge clk) begin
    exp_t e;
    if (rst) begin
      prev_p = 1'b0;
      prev_pulse = 1'b0;
    end else begin
      if (press_pulse) begin
        pulses_seen++;
        chk(pressed && !prev_p && !prev_pulse, "R6",
            "pulse outside first pressed cycle", int'(prev_p), 0);
      end
      if (pressed !== prev_p) begin
        if (sb_q.size() == 0) begin
          chk(1'b0, "R5", "unexpected pressed change", int'(pressed), int'(prev_p));
        end else begin
          e = sb_q.pop_front();
          chk((e.at_edge == ecnt - 1) && (e.lvl == pressed), pressed ? "R2" : "R4",
              "edge of pressed change", ecnt - 1, e.at_edge);
        end
      end
      prev_p = pressed;
      prev_pulse = press_pulse;
    end
  end

  initial begin
    int base;
    idle(10);
    chk(!pressed && !press_pulse, "R9", "outputs during reset", int'(pressed), 0);
    rst = 1'b0;
    idle(30);
    chk(!pressed, "R1", "pin high reads released", int'(pressed), 0);

    drive(1'b0, 1'b1);
    idle(40);
    chk(pressed, "R1", "pin low reads pressed", int'(pressed), 1);
    chk(pulses_seen == 1, "R6", "one pulse on press", pulses_seen, 1);

    base = pulses_seen;
    idle(300);
    chk(pressed, "R8", "held level stays high", int'(pressed), 1);
    chk(pulses_seen == base, "R8", "no repeat pulse while held", pulses_seen, base);

    drive(1'b1, 1'b1);
    idle(40);
    chk(!pressed, "R4", "release accepted", int'(pressed), 0);
    chk(pulses_seen == base, "R7", "no pulse on release", pulses_seen, base);

    for (int ph = 0; ph < PER; ph++) begin
      idle(ph + 1);
      drive(1'b0, 1'b1);
      idle(40);
      chk(pressed, "R3", "press at shifted phase", int'(pressed), 1);
      drive(1'b1, 1'b1);
      idle(40);
      chk(!pressed, "R3", "release at shifted phase", int'(pressed), 0);
    end

    bounce(1'b0, 6);
    drive(1'b0, 1'b1);
    idle(40);
    chk(pressed, "R5", "press after chatter", int'(pressed), 1);
    chk(pulses_seen == pulses_exp, "R5", "pulses after chatter", pulses_seen, pulses_exp);

    bounce(1'b1, 6);
    drive(1'b1, 1'b1);
    idle(40);
    chk(!pressed, "R5", "release after chatter", int'(pressed), 0);

    btn_n = 1'b0;
    idle(PER);
    btn_n = 1'b1;
    idle(40);
    chk(!pressed, "R4", "single-sample glitch ignored", int'(pressed), 0);

    drive(1'b0, 1'b1);
    idle(40);
    chk(pressed, "R9", "pressed before reset", int'(pressed), 1);
    rst = 1'b1;
    idle(3);
    chk(!pressed && !press_pulse, "R9", "reset clears outputs", int'(pressed), 0);
    rst = 1'b0;
    drive(1'b0, 1'b1);
    idle(40);
    chk(pressed, "R9", "restart from released after reset", int'(pressed), 1);
    drive(1'b1, 1'b1);
    idle(40);

    chk(sb_q.size() == 0, "R4", "all expected changes seen", sb_q.size(), 0);
    chk(pulses_seen == pulses_exp, "R6", "total pulses", pulses_seen, pulses_exp);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    ntests++;
    nfail++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule